// File: doc/BRIEF.md
# Asynchronous SRAM Access-Rule Monitor

This block watches the address bus, the data bus and the four control pins of an asynchronous static RAM interface and reports every breach of the memory's access rules. It samples those pins with a monitor clock that runs much faster than the memory cycle, and it never drives the bus. Every pin first goes through a two-stage synchronizer. All pins see the same two-cycle delay, so their timing relative to one another is kept and the rule thresholds need no adjustment.

The memory has an active-low select, an active-high enable, an active-low write strobe and an active-low output enable. The monitor rebuilds the write window and the read-qualified state from these pins. It times each window and gap in monitor clock periods and keeps one sticky flag per rule. A combined pulse marks each sample on which any rule broke. Two saturating counters record the writes and reads that completed correctly. The minimum write pulse width, minimum recovery gap, data setup, data hold and read access time are independent parameters in clock periods.

Top module: `sram_mon`

## Requirements
- R1: The write window is every sample with select low, enable high and write strobe low. If the address changes between two consecutive window samples, flag bit 0 is set.
- R2: If a window starts after a previous window and fewer than MIN_REC samples lay outside a window between them, flag bit 1 is set.
- R3: If a window lasts fewer than MIN_PW samples, flag bit 2 is set when the window ends.
- R4: Flag bit 3 is set in either of two cases. The first is a data change at the first sample after a window, or at any of the SETUP-1 samples before it. The second is a data change in any of the HOLD samples that follow that first sample.
- R5: The read-qualified state is select low, enable high, write strobe high and output enable low. Flag bit 4 is set when the block leaves this state through a change of select or enable before ACC samples have passed since the state began or the address last changed. Leaving the state through output enable or the write strobe sets no flag.
- R6: The write counter adds one at the end of each window that had no R1, R2, R3 or setup violation.
- R7: The read counter adds one when the read-qualified state has held the same address for ACC consecutive samples. It counts only once for each address.
- R8: Error flags stay set until `clr_err_i` is pulsed. A clear clears all flags.
- R9: `err_pulse_o` is high for one cycle for each pin sample on which at least one rule broke.
- R10: Both counters saturate at their all-ones value.
- R11: After reset, all flags, both counters and the pulse output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_err_i | input | 1 | Clears all sticky error flags |
| addr_i | input | AW | Observed address bus |
| data_i | input | DW | Observed data bus |
| sel_n_i | input | 1 | Observed select, active low |
| en_i | input | 1 | Observed enable, active high |
| wr_n_i | input | 1 | Observed write strobe, active low |
| oe_n_i | input | 1 | Observed output enable, active low |
| err_flags_o | output | 5 | Sticky flags: bit0 address, bit1 recovery, bit2 width, bit3 data timing, bit4 read |
| err_pulse_o | output | 1 | One-cycle pulse for each violating sample |
| wr_cnt_o | output | CNT_W | Count of valid writes, saturating |
| rd_cnt_o | output | CNT_W | Count of valid reads, saturating |

## Verification
The bench builds the monitor with small thresholds: 4-sample pulse width, 3-sample recovery, 2-sample setup and hold, and 3-sample access time. At these values every boundary sits a single sample from passing, so short random windows and gaps cross each limit often. It also sets an 8-bit address bus, 8-bit data bus and a 6-bit counter width. The short counter lets both counters reach saturation in a few hundred cycles.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
    localparam int NUM_RULES = 5;

    typedef enum logic [2:0] {
        RULE_ADDR  = 3'd0,
        RULE_RECOV = 3'd1,
        RULE_WIDTH = 3'd2,
        RULE_DATA  = 3'd3,
        RULE_READ  = 3'd4
    } rule_e;

    // bits needed to hold the value v
    function automatic int lim_bits(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction
endpackage

// File: rtl/sram_mon_sync.sv
module sram_mon_sync #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/sram_mon_wr.sv
module sram_mon_wr #(
    parameter int AW      = 15,
    parameter int DW      = 8,
    parameter int MIN_PW  = 6,
    parameter int MIN_REC = 4,
    parameter int SETUP   = 3,
    parameter int HOLD    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          ev_addr,
    output logic          ev_recov,
    output logic          ev_width,
    output logic          ev_data,
    output logic          wr_inc
);
    import sram_mon_pkg::*;

    localparam int PW_W = lim_bits(MIN_PW);
    localparam int RC_W = lim_bits(MIN_REC);
    localparam int SU_W = lim_bits(SETUP);
    localparam int HD_W = lim_bits(HOLD);
    localparam logic [PW_W-1:0] PW_LIM = PW_W'(MIN_PW);
    localparam logic [RC_W-1:0] RC_LIM = RC_W'(MIN_REC);
    localparam logic [SU_W-1:0] SU_LIM = SU_W'(SETUP);
    localparam logic [HD_W-1:0] HD_LIM = HD_W'(HOLD);

    typedef struct packed {
        logic            win;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        logic [PW_W-1:0] wlen;
        logic [RC_W-1:0] gap;
        logic            seen;
        logic [SU_W-1:0] dage;
        logic [HD_W-1:0] hcnt;
        logic            bad;
    } st_t;

    st_t  st_d, st_q;
    logic start, fin, dchg, setup_bad, hold_bad;

    always_comb begin
        st_d      = st_q;
        st_d.win  = win;
        st_d.addr = addr;
        st_d.data = data;

        start = win & ~st_q.win;
        fin   = ~win & st_q.win;
        dchg  = (data != st_q.data);

        if (dchg)                 st_d.dage = '0;
        else if (st_q.dage != SU_LIM) st_d.dage = st_q.dage + SU_W'(1);

        if (start)                               st_d.wlen = PW_W'(1);
        else if (win && (st_q.wlen != PW_LIM))   st_d.wlen = st_q.wlen + PW_W'(1);

        if (win)                        st_d.gap = '0;
        else if (fin)                   st_d.gap = RC_W'(1);
        else if (st_q.gap != RC_LIM)    st_d.gap = st_q.gap + RC_W'(1);

        ev_addr   = win & st_q.win & (addr != st_q.addr);
        ev_recov  = start & st_q.seen & (st_q.gap < RC_LIM);
        ev_width  = fin & (st_q.wlen < PW_LIM);
        setup_bad = fin & (st_d.dage < SU_LIM);
        hold_bad  = (st_q.hcnt != '0) & dchg & ~fin;
        ev_data   = setup_bad | hold_bad;

        if (fin)                    st_d.hcnt = HD_LIM;
        else if (st_q.hcnt != '0)   st_d.hcnt = st_q.hcnt - HD_W'(1);

        if (start) st_d.bad = ev_recov;
        else       st_d.bad = st_q.bad | ev_addr;

        if (fin) st_d.seen = 1'b1;

        wr_inc = fin & ~st_q.bad & ~ev_width & ~setup_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    wlen_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.win |-> (st_q.wlen != '0));
    // R2
    recov_needs_prior_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_recov |-> (st_q.seen && !st_q.win));
endmodule

// File: rtl/sram_mon_rd.sv
module sram_mon_rd #(
    parameter int AW  = 15,
    parameter int ACC = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rq,
    input  logic          sel_n,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic          ev_read,
    output logic          rd_inc
);
    import sram_mon_pkg::*;

    localparam int AC_W = lim_bits(ACC);
    localparam logic [AC_W-1:0] AC_LIM = AC_W'(ACC);
    localparam logic [AC_W-1:0] AC_PRE = AC_W'(ACC - 1);

    typedef struct packed {
        logic            rq;
        logic            sel_n;
        logic            en;
        logic [AW-1:0]   addr;
        logic [AC_W-1:0] age;
    } st_t;

    st_t  st_d, st_q;
    logic restart;

    always_comb begin
        st_d       = st_q;
        st_d.rq    = rq;
        st_d.sel_n = sel_n;
        st_d.en    = en;
        st_d.addr  = addr;

        restart = rq & (~st_q.rq | (addr != st_q.addr));

        if (!rq)                        st_d.age = '0;
        else if (restart)               st_d.age = AC_W'(1);
        else if (st_q.age != AC_LIM)    st_d.age = st_q.age + AC_W'(1);

        rd_inc  = rq & ~restart & (st_q.age == AC_PRE);
        ev_read = st_q.rq & ~rq & ((sel_n != st_q.sel_n) | (en != st_q.en))
                & (st_q.age < AC_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    read_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_inc |=> (st_q.age == AC_LIM));
endmodule

// File: rtl/sram_mon_cnt.sv
module sram_mon_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != MAXV)) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV) |=> (cnt_q == MAXV));
    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + W'(1))));
endmodule

// File: rtl/sram_mon.sv
module sram_mon #(
    parameter int AW      = 15,
    parameter int DW      = 8,
    parameter int MIN_PW  = 6,
    parameter int MIN_REC = 4,
    parameter int SETUP   = 3,
    parameter int HOLD    = 2,
    parameter int ACC     = 5,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_err_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    data_i,
    input  logic             sel_n_i,
    input  logic             en_i,
    input  logic             wr_n_i,
    input  logic             oe_n_i,
    output logic [4:0]       err_flags_o,
    output logic             err_pulse_o,
    output logic [CNT_W-1:0] wr_cnt_o,
    output logic [CNT_W-1:0] rd_cnt_o
);
    import sram_mon_pkg::*;

    localparam int SW = AW + DW + 4;
    localparam logic [SW-1:0] SYNC_RST = {4'b1101, {(AW + DW){1'b0}}};

    logic [SW-1:0]        raw, syn;
    logic [AW-1:0]        s_addr;
    logic [DW-1:0]        s_data;
    logic                 s_sel_n, s_en, s_wr_n, s_oe_n;
    logic                 win, rq;
    logic                 ev_addr, ev_recov, ev_width, ev_data, ev_read;
    logic                 wr_inc, rd_inc;
    logic [NUM_RULES-1:0] ev;

    assign raw = {oe_n_i, wr_n_i, en_i, sel_n_i, data_i, addr_i};

    sram_mon_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign {s_oe_n, s_wr_n, s_en, s_sel_n, s_data, s_addr} = syn;
    assign win = ~s_sel_n & s_en & ~s_wr_n;
    assign rq  = ~s_sel_n & s_en & s_wr_n & ~s_oe_n;

    sram_mon_wr #(
        .AW(AW), .DW(DW), .MIN_PW(MIN_PW), .MIN_REC(MIN_REC),
        .SETUP(SETUP), .HOLD(HOLD)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .win(win), .addr(s_addr), .data(s_data),
        .ev_addr(ev_addr), .ev_recov(ev_recov), .ev_width(ev_width),
        .ev_data(ev_data), .wr_inc(wr_inc)
    );

    sram_mon_rd #(.AW(AW), .ACC(ACC)) u_rd (
        .clk(clk), .rst_n(rst_n), .rq(rq), .sel_n(s_sel_n), .en(s_en),
        .addr(s_addr), .ev_read(ev_read), .rd_inc(rd_inc)
    );

    sram_mon_cnt #(.W(CNT_W)) u_wcnt (
        .clk(clk), .rst_n(rst_n), .inc(wr_inc), .cnt(wr_cnt_o)
    );

    sram_mon_cnt #(.W(CNT_W)) u_rcnt (
        .clk(clk), .rst_n(rst_n), .inc(rd_inc), .cnt(rd_cnt_o)
    );

    always_comb begin
        ev             = '0;
        ev[RULE_ADDR]  = ev_addr;
        ev[RULE_RECOV] = ev_recov;
        ev[RULE_WIDTH] = ev_width;
        ev[RULE_DATA]  = ev_data;
        ev[RULE_READ]  = ev_read;
    end

    typedef struct packed {
        logic [NUM_RULES-1:0] flags;
        logic                 pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (clr_err_i ? '0 : st_q.flags) | ev;
        st_d.pulse = |ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_flags_o = st_q.flags;
    assign err_pulse_o = st_q.pulse;

    // R9
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> (err_flags_o != '0));
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err_i |=> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o)));
    // R7
    read_inc_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_inc |-> (!s_sel_n && s_en && s_wr_n && !s_oe_n));
    // R6
    write_inc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inc |-> (!win && $past(win)));
endmodule

// File: tb/sram_mon_test.sv
module sram_mon_test;
    localparam int AW = 8, DW = 8, PW = 4, REC = 3, SU = 2, HD = 2, ACC = 3, CW = 6;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic sel_n = 1'b1, en = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
    logic [4:0] flags;
    logic pulse;
    logic [CW-1:0] wcnt, rcnt;

    int n_run = 0, n_fail = 0, n_pulse = 0;

    always #2 clk = ~clk;

    sram_mon #(.AW(AW), .DW(DW), .MIN_PW(PW), .MIN_REC(REC), .SETUP(SU),
               .HOLD(HD), .ACC(ACC), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clr_err_i(clr), .addr_i(addr), .data_i(data),
        .sel_n_i(sel_n), .en_i(en), .wr_n_i(wr_n), .oe_n_i(oe_n),
        .err_flags_o(flags), .err_pulse_o(pulse), .wr_cnt_o(wcnt), .rd_cnt_o(rcnt)
    );

    always @(negedge clk) if (rst_n && pulse) n_pulse++;

    // reference model state, in pin samples
    logic m_win = 0, m_seen = 0, m_bad = 0, m_rq = 0, m_sel = 1, m_en = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    int m_wlen = 0, m_gap = 0, m_dage = 100, m_hcnt = 0, m_age = 0;
    logic [4:0] e_flags = '0;
    int e_wr = 0, e_rd = 0, e_pulse = 0;

    function automatic int sat(input int v);
        return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
    endfunction

    task automatic model(input logic s, e, w, o, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic win, rq, start, fin, dchg, rst_age;
        logic [4:0] ev;
        ev = '0;
        win = !s && e && !w;
        rq  = !s && e && w && !o;
        start = win && !m_win;
        fin = !win && m_win;
        dchg = (d != m_data);
        m_dage = dchg ? 0 : m_dage + 1;
        if (win && m_win && a != m_addr) ev[0] = 1;                 // R1
        if (start && m_seen && m_gap < REC) ev[1] = 1;              // R2
        if (fin && m_wlen < PW) ev[2] = 1;                          // R3
        if (fin && m_dage < SU) ev[3] = 1;                          // R4 setup
        if (m_hcnt > 0 && dchg && !fin) ev[3] = 1;                  // R4 hold
        if (fin && !m_bad && !ev[2] && !(m_dage < SU)) e_wr = sat(e_wr + 1);
        m_bad = start ? ev[1] : (m_bad | ev[0]);
        m_wlen = start ? 1 : (win ? m_wlen + 1 : m_wlen);
        m_gap = win ? 0 : (fin ? 1 : m_gap + 1);
        m_hcnt = fin ? HD : (m_hcnt > 0 ? m_hcnt - 1 : 0);
        if (fin) m_seen = 1;
        rst_age = rq && (!m_rq || a != m_addr);
        if (m_rq && !rq && (s != m_sel || e != m_en) && m_age < ACC) ev[4] = 1;  // R5
        if (!rq) m_age = 0;
        else if (rst_age) m_age = 1;
        else begin
            m_age = m_age + 1;
            if (m_age == ACC) e_rd = sat(e_rd + 1);                 // R7
        end
        m_win = win; m_rq = rq; m_sel = s; m_en = e; m_addr = a; m_data = d;
        e_flags |= ev;
        if (ev != 0) e_pulse++;
    endtask

    task automatic step(input logic s, e, w, o, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        sel_n = s; en = e; wr_n = w; oe_n = o; addr = a; data = d;
        model(s, e, w, o, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b1, 1'b1, addr, data);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle_check(input string req);
        idle(6);
        @(negedge clk);
        chk({req, " flags"}, int'(flags), int'(e_flags));
        chk({req, " writes"}, int'(wcnt), e_wr);
        chk({req, " reads"}, int'(rcnt), e_rd);
        chk({req, " pulses"}, n_pulse, e_pulse);
    endtask

    task automatic clear();
        @(posedge clk); #1; clr = 1'b1;
        @(posedge clk); #1; clr = 1'b0;
        e_flags = '0;
    endtask

    task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
        step(1'b0, 1'b1, 1'b1, 1'b1, a, d);
        for (int i = 0; i < len; i++) step(1'b0, 1'b1, 1'b0, 1'b1, a, d);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd_op(input logic [AW-1:0] a, input int len);
        for (int i = 0; i < len; i++) step(1'b0, 1'b1, 1'b1, 1'b0, a, data);
    endtask

    logic done = 1'b0;
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int wr0, p0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk("R11 flags", int'(flags), 0);
        chk("R11 writes", int'(wcnt), 0);
        chk("R11 reads", int'(rcnt), 0);
        chk("R11 pulse", int'(pulse), 0);
        idle(3);
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);

        // R6 good write
        wr_op(8'h11, 8'hA5, 5);
        settle_check("R6");
        chk("R6 good write counted", int'(wcnt), 1);
        chk("R6 no flags", int'(flags), 0);

        // R3 short window
        wr_op(8'h12, 8'hA5, 2);
        settle_check("R3");
        chk("R3 width bit", int'(flags), 5'b00100);
        clear();

        // R1 two address changes inside a window; R9 one pulse each
        p0 = e_pulse;
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h20, 8'h5A);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h20, 8'h5A);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h21, 8'h5A);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h21, 8'h5A);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h22, 8'h5A);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h22, 8'h5A);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h22, 8'h5A);
        settle_check("R1");
        chk("R1 address bit", int'(flags), 5'b00001);
        chk("R9 two pulses", e_pulse - p0, 2);
        clear();
        chk("R8 cleared", int'(flags), 0);

        // R2 short gap between windows
        wr0 = e_wr;
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h33);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 8'h30, 8'h33);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h33);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 8'h30, 8'h33);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h33);
        settle_check("R2");
        chk("R2 recovery bit", int'(flags), 5'b00010);
        chk("R2 only first counted", e_wr - wr0, 1);
        clear();

        // R4 setup: data changes on last window sample
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h40, 8'h01);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 8'h40, 8'h01);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h40, 8'h02);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h40, 8'h02);
        settle_check("R4 setup");
        chk("R4 setup bit", int'(flags), 5'b01000);
        clear();

        // R4 hold: change one sample after window end
        wr_op(8'h41, 8'h03, 5);
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h41, 8'h03);
        settle_check("R4 hold pre");
        chk("R4 clean write", int'(flags), 0);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h42, 8'h04);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 8'h42, 8'h04);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h42, 8'h04);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h42, 8'h05);
        settle_check("R4 hold");
        chk("R4 hold bit", int'(flags), 5'b01000);
        clear();

        // R7 valid read, R5 aborted by select, and output-enable exit ignored
        rd_op(8'h50, 4);
        settle_check("R7");
        chk("R7 read counted", int'(rcnt), 1);
        rd_op(8'h51, 2);
        settle_check("R5");
        chk("R5 read bit", int'(flags), 5'b10000);
        clear();
        rd_op(8'h52, 1);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h52, data);
        settle_check("R5 oe exit");
        chk("R5 oe exit no flag", int'(flags), 0);

        // random mix checked against the model
        void'($urandom(32'd1234));
        for (int it = 0; it < 60; it++) begin
            int kind = $urandom_range(0, 2);
            logic [AW-1:0] a = AW'($urandom);
            logic [DW-1:0] d = DW'($urandom);
            if (kind == 0) begin
                int len = $urandom_range(1, 7);
                int hit = $urandom_range(0, 9);
                step(1'b0, 1'b1, 1'b1, 1'b1, a, d);
                for (int i = 0; i < len; i++)
                    step(1'b0, 1'b1, 1'b0, 1'b1, (hit == i) ? a + 1'b1 : a,
                         (hit == i + 3) ? d ^ 8'h1 : d);
                for (int i = 0; i < $urandom_range(1, 4); i++)
                    step(1'b0, 1'b1, 1'b1, 1'b1, a, (hit == 9) ? d ^ 8'h2 : d);
                if ($urandom_range(0, 1) == 1)
                    for (int i = 0; i < $urandom_range(2, 6); i++)
                        step(1'b0, 1'b1, 1'b0, 1'b1, a, d);
                step(1'b0, 1'b1, 1'b1, 1'b1, a, d);
            end else if (kind == 1) begin
                rd_op(a, $urandom_range(1, 6));
                rd_op(a + 1'b1, $urandom_range(1, 4));
                step(1'b0, $urandom_range(0, 1) == 1, 1'b1, 1'b0, a, data);
            end else begin
                rd_op(a, $urandom_range(1, 5));
                step(1'b1, 1'b0, 1'b1, 1'b1, a, data);
            end
            settle_check("R1 R2 R3 R4 R5 R6 R7 random");
            clear();
        end

        // R10 saturation of both counters
        for (int i = 0; i < 70; i++) rd_op(AW'(i), ACC);
        for (int i = 0; i < 70; i++) wr_op(AW'(i), 8'h77, PW);
        settle_check("R10");
        chk("R10 read saturates", int'(rcnt), 63);
        chk("R10 write saturates", int'(wcnt), 63);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule